// File: doc/BRIEF.md
# Machine CSR Write Legalizer

This block is the machine-level control and status register bank of a processor hart. It holds a status word, interrupt pending and enable words, interrupt and exception delegation masks, machine and supervisor trap vectors, and a feature word. All writes arrive on one write port and are legalized field by field. Bits that software may not change keep their value. Privilege fields are forced to a level the hart implements. Derived fields are computed rather than stored.

The supervisor status, pending and enable views have no storage of their own. They are masked windows onto the machine registers. A write through a view reaches only the machine bits that the view exposes. A status write that alters any field affecting address translation raises a one-cycle flush strobe, so that translation caches can be invalidated. Reads are combinational. A read of an address outside the map returns zero and raises an illegal-access flag.

Top module: `csr_legalizer`

## Requirements
- R1: The previous-privilege field of the status word (bits 12:11) is legalized on every full status write. Without user-level support it becomes 3. If the written value is 2, or supervisor level is absent, it becomes 0. Any other value is kept. After reset it holds the legalized form of 0.
- R2: The most significant status bit reads 1 exactly when the float state field (bits 14:13) or the extension state field (bits 16:15) equals 3. Software cannot write this bit.
- R3: With XLEN=64, status bits 33:32 and 35:34 always read 2. With XLEN=32 these fields do not exist.
- R4: The pending word (address 2) accepts writes only to bits 1 and 5. All its other bits read 0.
- R5: The enable word (address 4) accepts bits 1, 3, 5, 7, 9 and 12. The interrupt delegation word (address 6) accepts bits 1, 5, 9 and 12.
- R6: The exception delegation word (address 7) accepts bits 0, 3, 8, 12, 13 and 15.
- R7: A write to the machine vector (address 8) stores bit 1 as 0. A write to the supervisor vector (address 9) stores bits 1:0 as 0.
- R8: The feature word (address 10) has its letter bits at 25:0 and the width code (1 for 32, 2 for 64) in its top two bits.
  - Writes change only letter bits 0, 2, 3, 5 and 12, and only those present in the reset set.
  - A written value with bit 5 clear also clears bit 3.
  - At reset, bit 18 is set when supervisor level exists and bit 20 when user level exists.
- R9: In the cycle after a write to address 0 or 1, `flush_o` is 1 exactly when that write changed the stored value of bits 12:11, 17, 18 or 19. Otherwise `flush_o` is 0.
- R10: Supervisor views.
  - Address 1 reads and writes status bits 1, 5, 8, 13 to 16, 18 and 19. Reads also return bits 33:32 and the most significant bit.
  - Address 3 reads the pending word ANDed with delegation; a write there changes only bit 1, and only if bit 1 is delegated.
  - Address 5 reads the enable word ANDed with delegation; a write there changes only enable bits that are delegated.
- R11: A full status write (address 0) changes bits 1, 3, 5, 7, 13, 14 and 17 to 22. Bit 8 changes only when supervisor level exists, and bits 16:15 only when extension state is configured. All other stored bits stay 0.
- R12: Addresses 0 to 10 are mapped. A read of addresses 11 to 15 returns zero with `rd_bad` high. A write to those addresses changes nothing.
- R13: After reset, every register is zero, except the legalized privilege field, the feature word and the fixed status fields. `flush_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | XLEN | Write data before legalization |
| rd_addr | input | 4 | Read address |
| rd_data | output | XLEN | Read data, composed combinationally |
| rd_bad | output | 1 | Read address is not mapped |
| flush_o | output | 1 | One-cycle translation flush strobe |

## Verification
The bench builds three copies side by side.
- A 64-bit copy with user, supervisor and extension state reaches the width fields, the extension-state half of the dirty summary, and the supervisor-alias bit 8.
- A 32-bit copy without supervisor level shows the privilege field collapsing to 0 and bit 8 staying frozen.
- A 32-bit copy without user level shows the field pinned at 3, and covers a feature set lacking D and F.

A walking one and several fill patterns go to every address, including the unmapped ones. After each write, all sixteen addresses are read back from all three copies and compared with arithmetic expectations.

// File: rtl/csr_leg_pkg.sv
package csr_leg_pkg;

  localparam int AW         = 4;
  localparam int NUM_MAPPED = 11;

  localparam logic [AW-1:0] A_STAT   = 4'd0;
  localparam logic [AW-1:0] A_SSTAT  = 4'd1;
  localparam logic [AW-1:0] A_IPEND  = 4'd2;
  localparam logic [AW-1:0] A_SIPEND = 4'd3;
  localparam logic [AW-1:0] A_IENAB  = 4'd4;
  localparam logic [AW-1:0] A_SIENAB = 4'd5;
  localparam logic [AW-1:0] A_IDLG   = 4'd6;
  localparam logic [AW-1:0] A_EDLG   = 4'd7;
  localparam logic [AW-1:0] A_MVEC   = 4'd8;
  localparam logic [AW-1:0] A_SVEC   = 4'd9;
  localparam logic [AW-1:0] A_FEAT   = 4'd10;

  // status word fields
  localparam int MPP_LO = 11;
  localparam int FS_LO  = 13;
  localparam int XS_LO  = 15;
  localparam logic [63:0] F_SIE  = 64'd1 << 1;
  localparam logic [63:0] F_MIE  = 64'd1 << 3;
  localparam logic [63:0] F_SPIE = 64'd1 << 5;
  localparam logic [63:0] F_MPIE = 64'd1 << 7;
  localparam logic [63:0] F_SPP  = 64'd1 << 8;
  localparam logic [63:0] F_MPP  = 64'd3 << MPP_LO;
  localparam logic [63:0] F_FS   = 64'd3 << FS_LO;
  localparam logic [63:0] F_XS   = 64'd3 << XS_LO;
  localparam logic [63:0] F_MPRV = 64'd1 << 17;
  localparam logic [63:0] F_SUM  = 64'd1 << 18;
  localparam logic [63:0] F_MXR  = 64'd1 << 19;
  localparam logic [63:0] F_TVM  = 64'd1 << 20;
  localparam logic [63:0] F_TW   = 64'd1 << 21;
  localparam logic [63:0] F_TSR  = 64'd1 << 22;
  localparam logic [63:0] F_UXL  = 64'd3 << 32;
  localparam logic [63:0] F_SXL  = 64'd3 << 34;

  localparam logic [63:0] STAT_BASE_WM = F_SIE | F_MIE | F_SPIE | F_MPIE | F_FS
                                       | F_MPRV | F_SUM | F_MXR | F_TVM | F_TW | F_TSR;
  localparam logic [63:0] SVIEW_M  = F_SIE | F_SPIE | F_SPP | F_FS | F_XS | F_SUM | F_MXR;
  localparam logic [63:0] FLUSH_M  = F_MPP | F_MPRV | F_SUM | F_MXR;

  // interrupt and exception masks
  localparam logic [63:0] IP_SW_M  = 64'h0022;
  localparam logic [63:0] IP_SSIP  = 64'h0002;
  localparam logic [63:0] IE_M     = 64'h12AA;
  localparam logic [63:0] IDLG_M   = 64'h1222;
  localparam logic [63:0] EDLG_M   = 64'hB109;

  // feature letters
  localparam int FEAT_W = 26;
  localparam logic [FEAT_W-1:0] FEAT_ALT_M = 26'h102D;
  localparam int FEAT_D = 3;
  localparam int FEAT_F = 5;
  localparam int FEAT_S = 18;
  localparam int FEAT_U = 20;

  function automatic logic [63:0] merge64(logic [63:0] old_v, logic [63:0] new_v,
                                          logic [63:0] mask);
    return (old_v & ~mask) | (new_v & mask);
  endfunction

  function automatic logic [1:0] legal_lvl(logic [1:0] req, bit has_u, bit has_s);
    if (!has_u)                    return 2'd3;
    if (req == 2'd2 || !has_s)     return 2'd0;
    return req;
  endfunction

  function automatic logic [1:0] xl_code(int xlen);
    return (xlen == 32) ? 2'd1 : 2'd2;
  endfunction

  function automatic logic [63:0] xl_fields(int xlen);
    if (xlen == 64) return (64'(xl_code(xlen)) << 32) | (64'(xl_code(xlen)) << 34);
    return 64'd0;
  endfunction

  function automatic logic dirty_sum(logic [63:0] s);
    return (s[FS_LO +: 2] == 2'd3) || (s[XS_LO +: 2] == 2'd3);
  endfunction

  function automatic logic [FEAT_W-1:0] feat_merge(logic [FEAT_W-1:0] old_v,
                                                   logic [FEAT_W-1:0] wr_v,
                                                   logic [FEAT_W-1:0] mask);
    logic [FEAT_W-1:0] d;
    d = wr_v;
    if (!d[FEAT_F]) d[FEAT_D] = 1'b0;
    return (old_v & ~mask) | (d & mask);
  endfunction

endpackage

// File: rtl/csr_stat_reg.sv
module csr_stat_reg
  import csr_leg_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter bit HAS_U  = 1'b1,
  parameter bit HAS_S  = 1'b1,
  parameter bit HAS_XS = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we_full,
  input  logic            we_sview,
  input  logic [XLEN-1:0] wdata,
  output logic [XLEN-1:0] stat_o,
  output logic [XLEN-1:0] sview_o,
  output logic            flush_o
);
  localparam logic [63:0] WM64   = STAT_BASE_WM | (HAS_S ? F_SPP : 64'd0)
                                 | (HAS_XS ? F_XS : 64'd0);
  localparam logic [63:0] SWM64  = WM64 & SVIEW_M;
  localparam logic [63:0] XLF64  = xl_fields(XLEN);
  localparam logic [63:0] SVR64  = SVIEW_M | F_UXL;
  localparam logic [1:0]  MPP_RST = legal_lvl(2'd0, HAS_U, HAS_S);
  localparam logic [63:0] RST64  = 64'(MPP_RST) << MPP_LO;
  localparam logic [XLEN-1:0] FL_M = FLUSH_M[XLEN-1:0];
  localparam logic [XLEN-1:0] XLF  = XLF64[XLEN-1:0];
  localparam logic [XLEN-1:0] SVR  = SVR64[XLEN-1:0];

  logic [XLEN-1:0] q, nxt;
  logic            chg, sd;

  always_comb begin
    nxt = q;
    if (we_full) begin
      nxt = XLEN'(merge64(64'(q), 64'(wdata), WM64));
      nxt[MPP_LO +: 2] = legal_lvl(wdata[MPP_LO +: 2], HAS_U, HAS_S);
    end else if (we_sview) begin
      nxt = XLEN'(merge64(64'(q), 64'(wdata), SWM64));
    end
  end

  assign chg = ((nxt ^ q) & FL_M) != '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q       <= RST64[XLEN-1:0];
      flush_o <= 1'b0;
    end else begin
      q       <= nxt;
      flush_o <= (we_full || we_sview) && chg;
    end
  end

  assign sd = dirty_sum(64'(q));

  always_comb begin
    stat_o            = q | XLF;
    stat_o[XLEN-1]    = sd;
    sview_o           = stat_o & SVR;
    sview_o[XLEN-1]   = sd;
  end
endmodule

// File: rtl/csr_irq_regs.sv
module csr_irq_regs
  import csr_leg_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we_ip,
  input  logic            we_sip,
  input  logic            we_ie,
  input  logic            we_sie,
  input  logic            we_dlg,
  input  logic [XLEN-1:0] wdata,
  output logic [XLEN-1:0] ip_o,
  output logic [XLEN-1:0] ie_o,
  output logic [XLEN-1:0] dlg_o
);
  localparam logic [XLEN-1:0] IPM  = IP_SW_M[XLEN-1:0];
  localparam logic [XLEN-1:0] SSIP = IP_SSIP[XLEN-1:0];
  localparam logic [XLEN-1:0] IEM  = IE_M[XLEN-1:0];
  localparam logic [XLEN-1:0] DLM  = IDLG_M[XLEN-1:0];

  logic [XLEN-1:0] ip_q, ie_q, dlg_q;
  logic [XLEN-1:0] ip_wm, ie_wm;

  always_comb begin
    ip_wm = '0;
    if (we_ip)       ip_wm = IPM;
    else if (we_sip) ip_wm = SSIP & dlg_q;
    ie_wm = '0;
    if (we_ie)       ie_wm = IEM;
    else if (we_sie) ie_wm = IEM & dlg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ip_q  <= '0;
      ie_q  <= '0;
      dlg_q <= '0;
    end else begin
      ip_q <= XLEN'(merge64(64'(ip_q), 64'(wdata), 64'(ip_wm)));
      ie_q <= XLEN'(merge64(64'(ie_q), 64'(wdata), 64'(ie_wm)));
      if (we_dlg) dlg_q <= XLEN'(merge64(64'(dlg_q), 64'(wdata), 64'(DLM)));
    end
  end

  assign ip_o  = ip_q;
  assign ie_o  = ie_q;
  assign dlg_o = dlg_q;
endmodule

// File: rtl/csr_trap_regs.sv
module csr_trap_regs
  import csr_leg_pkg::*;
#(
  parameter int               XLEN      = 64,
  parameter bit               HAS_U     = 1'b1,
  parameter bit               HAS_S     = 1'b1,
  parameter logic [FEAT_W-1:0] FEAT_INIT = 26'h112D
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we_edlg,
  input  logic            we_mvec,
  input  logic            we_svec,
  input  logic            we_feat,
  input  logic [XLEN-1:0] wdata,
  output logic [XLEN-1:0] edlg_o,
  output logic [XLEN-1:0] mvec_o,
  output logic [XLEN-1:0] svec_o,
  output logic [XLEN-1:0] feat_o
);
  localparam logic [FEAT_W-1:0] FEAT_RST = FEAT_INIT
                                         | (HAS_S ? (26'd1 << FEAT_S) : 26'd0)
                                         | (HAS_U ? (26'd1 << FEAT_U) : 26'd0);
  localparam logic [FEAT_W-1:0] FEAT_WM  = FEAT_ALT_M & FEAT_INIT;
  localparam logic [XLEN-1:0]   EDM      = EDLG_M[XLEN-1:0];

  logic [XLEN-1:0]   edlg_q, mvec_q, svec_q;
  logic [FEAT_W-1:0] feat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edlg_q <= '0;
      mvec_q <= '0;
      svec_q <= '0;
      feat_q <= FEAT_RST;
    end else begin
      if (we_edlg) edlg_q <= XLEN'(merge64(64'(edlg_q), 64'(wdata), 64'(EDM)));
      if (we_mvec) mvec_q <= {wdata[XLEN-1:2], 1'b0, wdata[0]};
      if (we_svec) svec_q <= {wdata[XLEN-1:2], 2'b00};
      if (we_feat) feat_q <= feat_merge(feat_q, wdata[FEAT_W-1:0], FEAT_WM);
    end
  end

  always_comb begin
    feat_o               = '0;
    feat_o[XLEN-1 -: 2]  = xl_code(XLEN);
    feat_o[FEAT_W-1:0]   = feat_q;
  end

  assign edlg_o = edlg_q;
  assign mvec_o = mvec_q;
  assign svec_o = svec_q;
endmodule

// File: rtl/csr_legalizer.sv
module csr_legalizer
  import csr_leg_pkg::*;
#(
  parameter int                XLEN      = 64,
  parameter bit                HAS_U     = 1'b1,
  parameter bit                HAS_S     = 1'b1,
  parameter bit                HAS_XS    = 1'b0,
  parameter logic [FEAT_W-1:0] FEAT_INIT = 26'h112D
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [3:0]      wr_addr,
  input  logic [XLEN-1:0] wr_data,
  input  logic [3:0]      rd_addr,
  output logic [XLEN-1:0] rd_data,
  output logic            rd_bad,
  output logic            flush_o
);
  logic [NUM_MAPPED-1:0] wr_sel;
  logic                  wr_unmapped;
  logic [XLEN-1:0] stat_v, sview_v, ip_v, ie_v, dlg_v, edlg_v, mvec_v, svec_v, feat_v;

  for (genvar i = 0; i < NUM_MAPPED; i++) begin : g_dec
    assign wr_sel[i] = wr_en && (wr_addr == 4'(i));
  end
  assign wr_unmapped = wr_en && (wr_addr >= 4'(NUM_MAPPED));

  csr_stat_reg #(.XLEN(XLEN), .HAS_U(HAS_U), .HAS_S(HAS_S), .HAS_XS(HAS_XS)) u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .we_full  (wr_sel[A_STAT]),
    .we_sview (wr_sel[A_SSTAT]),
    .wdata    (wr_data),
    .stat_o   (stat_v),
    .sview_o  (sview_v),
    .flush_o  (flush_o)
  );

  csr_irq_regs #(.XLEN(XLEN)) u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .we_ip  (wr_sel[A_IPEND]),
    .we_sip (wr_sel[A_SIPEND]),
    .we_ie  (wr_sel[A_IENAB]),
    .we_sie (wr_sel[A_SIENAB]),
    .we_dlg (wr_sel[A_IDLG]),
    .wdata  (wr_data),
    .ip_o   (ip_v),
    .ie_o   (ie_v),
    .dlg_o  (dlg_v)
  );

  csr_trap_regs #(.XLEN(XLEN), .HAS_U(HAS_U), .HAS_S(HAS_S), .FEAT_INIT(FEAT_INIT)) u_trap (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_edlg (wr_sel[A_EDLG]),
    .we_mvec (wr_sel[A_MVEC]),
    .we_svec (wr_sel[A_SVEC]),
    .we_feat (wr_sel[A_FEAT]),
    .wdata   (wr_data),
    .edlg_o  (edlg_v),
    .mvec_o  (mvec_v),
    .svec_o  (svec_v),
    .feat_o  (feat_v)
  );

  always_comb begin
    rd_bad  = 1'b0;
    rd_data = '0;
    case (rd_addr)
      A_STAT:   rd_data = stat_v;
      A_SSTAT:  rd_data = sview_v;
      A_IPEND:  rd_data = ip_v;
      A_SIPEND: rd_data = ip_v & dlg_v;
      A_IENAB:  rd_data = ie_v;
      A_SIENAB: rd_data = ie_v & dlg_v;
      A_IDLG:   rd_data = dlg_v;
      A_EDLG:   rd_data = edlg_v;
      A_MVEC:   rd_data = mvec_v;
      A_SVEC:   rd_data = svec_v;
      A_FEAT:   rd_data = feat_v;
      default:  rd_bad  = 1'b1;
    endcase
  end
endmodule

// File: rtl/csr_legalizer_chk.sv
module csr_legalizer_chk
  import csr_leg_pkg::*;
#(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic [3:0]      wr_addr,
  input logic            wr_unmapped,
  input logic            flush_o,
  input logic [XLEN-1:0] stat_v,
  input logic [XLEN-1:0] ip_v,
  input logic [XLEN-1:0] ie_v,
  input logic [XLEN-1:0] dlg_v,
  input logic [XLEN-1:0] edlg_v,
  input logic [XLEN-1:0] mvec_v,
  input logic [XLEN-1:0] svec_v,
  input logic [XLEN-1:0] feat_v
);
  localparam logic [XLEN-1:0] IPM = IP_SW_M[XLEN-1:0];
  localparam logic [XLEN-1:0] DLM = IDLG_M[XLEN-1:0];
  localparam logic [XLEN-1:0] EDM = EDLG_M[XLEN-1:0];

  // R1
  mpp_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_v[MPP_LO +: 2] != 2'd2);

  // R4
  ip_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ip_v & ~IPM) == '0);

  // R5
  dlg_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dlg_v & ~DLM) == '0);

  // R6
  edlg_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edlg_v & ~EDM) == '0);

  // R7
  vec_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mvec_v[1] == 1'b0) && (svec_v[1:0] == 2'b00));

  // R9
  flush_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |-> $past(wr_en && (wr_addr == A_STAT || wr_addr == A_SSTAT)));

  // R10
  sie_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_SIENAB) |=> ((ie_v ^ $past(ie_v)) & ~$past(dlg_v)) == '0);

  // R12
  unmapped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_unmapped |=> $stable(stat_v) && $stable(ip_v) && $stable(ie_v) && $stable(dlg_v)
                 && $stable(edlg_v) && $stable(mvec_v) && $stable(svec_v) && $stable(feat_v));
endmodule

bind csr_legalizer csr_legalizer_chk #(.XLEN(XLEN)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .wr_addr     (wr_addr),
  .wr_unmapped (wr_unmapped),
  .flush_o     (flush_o),
  .stat_v      (stat_v),
  .ip_v        (ip_v),
  .ie_v        (ie_v),
  .dlg_v       (dlg_v),
  .edlg_v      (edlg_v),
  .mvec_v      (mvec_v),
  .svec_v      (svec_v),
  .feat_v      (feat_v)
);

// File: tb/tb_csr_legalizer.sv
`timescale 1ns/1ps
module tb_csr_legalizer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [63:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [63:0] rd_a;
  logic [31:0] rd_b, rd_c;
  logic        bad_a, bad_b, bad_c, fl_a, fl_b, fl_c;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  csr_legalizer #(.XLEN(64), .HAS_U(1'b1), .HAS_S(1'b1), .HAS_XS(1'b1), .FEAT_INIT(26'h112D)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_a), .rd_bad(bad_a), .flush_o(fl_a));
  csr_legalizer #(.XLEN(32), .HAS_U(1'b1), .HAS_S(1'b0), .HAS_XS(1'b0), .FEAT_INIT(26'h1125)) dut_b (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data[31:0]),
    .rd_addr(rd_addr), .rd_data(rd_b), .rd_bad(bad_b), .flush_o(fl_b));
  csr_legalizer #(.XLEN(32), .HAS_U(1'b0), .HAS_S(1'b0), .HAS_XS(1'b0), .FEAT_INIT(26'h1104)) dut_c (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data[31:0]),
    .rd_addr(rd_addr), .rd_data(rd_c), .rd_bad(bad_c), .flush_o(fl_c));

  int          cx[3] = '{64, 32, 32};
  bit          cu[3] = '{1'b1, 1'b1, 1'b0};
  bit          cs[3] = '{1'b1, 1'b0, 1'b0};
  bit          cxs[3] = '{1'b1, 1'b0, 1'b0};
  logic [25:0] cf[3] = '{26'h112D, 26'h1125, 26'h1104};

  logic [63:0] m_st[3], m_ip[3], m_ie[3], m_dl[3], m_ed[3], m_mv[3], m_sv[3];
  logic [25:0] m_ft[3];
  bit          m_fl[3];

  function automatic logic [63:0] wmask(int k);
    return (cx[k] == 64) ? ~64'd0 : 64'hFFFF_FFFF;
  endfunction

  function automatic logic [1:0] lvl(int k, logic [1:0] r);
    if (!cu[k]) return 2'd3;
    if (!cs[k] || r == 2'd2) return 2'd0;
    return r;
  endfunction

  function automatic logic [63:0] st_wm(int k);
    logic [63:0] m;
    m = 64'h0000_00AA | (64'd3 << 13) | (64'h3F << 17);
    if (cs[k])  m |= 64'h100;
    if (cxs[k]) m |= 64'd3 << 15;
    return m;
  endfunction

  function automatic logic [63:0] sd_xl(int k, logic [63:0] s, bit full);
    logic [63:0] r = 64'd0;
    if (s[14:13] == 2'd3 || s[16:15] == 2'd3) r |= 64'd1 << (cx[k] - 1);
    if (cx[k] == 64) r |= full ? 64'hA_0000_0000 : 64'h2_0000_0000;
    return r;
  endfunction

  function automatic logic [63:0] exp_rd(int k, int a);
    logic [63:0] sv_bits = 64'h22 | 64'h100 | (64'hF << 13) | (64'd3 << 18);
    case (a)
      0:  return m_st[k] | sd_xl(k, m_st[k], 1'b1);
      1:  return (m_st[k] & sv_bits) | sd_xl(k, m_st[k], 1'b0);
      2:  return m_ip[k];
      3:  return m_ip[k] & m_dl[k];
      4:  return m_ie[k];
      5:  return m_ie[k] & m_dl[k];
      6:  return m_dl[k];
      7:  return m_ed[k];
      8:  return m_mv[k];
      9:  return m_sv[k];
      10: return ((cx[k] == 64) ? (64'd2 << 62) : (64'd1 << 30)) | 64'(m_ft[k]);
      default: return 64'd0;
    endcase
  endfunction

  function automatic string tag_of(int a);
    case (a)
      0: return "R11";
      1, 3, 5: return "R10";
      2: return "R4";
      4, 6: return "R5";
      7: return "R6";
      8, 9: return "R7";
      10: return "R8";
      default: return "R12";
    endcase
  endfunction

  function automatic logic [63:0] got_rd(int k);
    return (k == 0) ? rd_a : (k == 1) ? 64'(rd_b) : 64'(rd_c);
  endfunction
  function automatic logic got_bad(int k);
    return (k == 0) ? bad_a : (k == 1) ? bad_b : bad_c;
  endfunction
  function automatic logic got_fl(int k);
    return (k == 0) ? fl_a : (k == 1) ? fl_b : fl_c;
  endfunction

  task automatic cmp(string tag, int k, int a, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s cfg%0d addr%0d got %h exp %h", tag, k, a, got, exp);
    end
  endtask

  task automatic model_reset();
    for (int k = 0; k < 3; k++) begin
      m_st[k] = 64'(lvl(k, 2'd0)) << 11;
      m_ip[k] = 0; m_ie[k] = 0; m_dl[k] = 0; m_ed[k] = 0; m_mv[k] = 0; m_sv[k] = 0;
      m_ft[k] = cf[k] | (cs[k] ? 26'h4_0000 : 26'h0) | (cu[k] ? 26'h10_0000 : 26'h0);
      m_fl[k] = 1'b0;
    end
  endtask

  task automatic model_write(int a, logic [63:0] data);
    for (int k = 0; k < 3; k++) begin
      logic [63:0] d = data & wmask(k);
      logic [63:0] o = m_st[k];
      logic [63:0] wm = st_wm(k);
      logic [63:0] fm = (64'd3 << 11) | (64'd7 << 17);
      logic [25:0] fd = d[25:0];
      m_fl[k] = 1'b0;
      case (a)
        0: begin
          m_st[k] = (o & ~wm) | (d & wm);
          m_st[k][12:11] = lvl(k, d[12:11]);
          m_fl[k] = ((m_st[k] ^ o) & fm) != 0;
        end
        1: begin
          wm = wm & (64'h122 | (64'hF << 13) | (64'd3 << 18));
          m_st[k] = (o & ~wm) | (d & wm);
          m_fl[k] = ((m_st[k] ^ o) & fm) != 0;
        end
        2: m_ip[k] = (m_ip[k] & ~64'h22) | (d & 64'h22);
        3: m_ip[k] = (m_ip[k] & ~(64'h2 & m_dl[k])) | (d & 64'h2 & m_dl[k]);
        4: m_ie[k] = (m_ie[k] & ~64'h12AA) | (d & 64'h12AA);
        5: m_ie[k] = (m_ie[k] & ~(64'h12AA & m_dl[k])) | (d & 64'h12AA & m_dl[k]);
        6: m_dl[k] = (m_dl[k] & ~64'h1222) | (d & 64'h1222);
        7: m_ed[k] = (m_ed[k] & ~64'hB109) | (d & 64'hB109);
        8: m_mv[k] = d & ~64'd2;
        9: m_sv[k] = d & ~64'd3;
        10: begin
          if (!fd[5]) fd[3] = 1'b0;
          m_ft[k] = (m_ft[k] & ~(26'h102D & cf[k])) | (fd & 26'h102D & cf[k]);
        end
        default: ;
      endcase
    end
  endtask

  task automatic check_all(string phase);
    for (int a = 0; a < 16; a++) begin
      @(negedge clk);
      rd_addr = 4'(a);
      #1;
      for (int k = 0; k < 3; k++) begin
        logic [63:0] g = got_rd(k);
        logic [63:0] e = exp_rd(k, a);
        cmp({phase, " R12 rd_bad"}, k, a, 64'(got_bad(k)), 64'(a > 10));
        if (a == 0) begin
          cmp({phase, " R1 prev-level"}, k, a, 64'(g[12:11]), 64'(e[12:11]));
          cmp({phase, " R2 dirty summary"}, k, a, 64'(g[cx[k]-1]), 64'(e[cx[k]-1]));
          if (cx[k] == 64) cmp({phase, " R3 width fields"}, k, a, 64'(g[35:32]), 64'hA);
        end
        cmp({phase, " ", tag_of(a)}, k, a, g, e);
      end
    end
  endtask

  task automatic do_write(int a, logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = d;
    model_write(a, d);
    @(negedge clk);
    wr_en = 1'b0;
    #1;
    for (int k = 0; k < 3; k++) cmp("R9 flush", k, a, 64'(got_fl(k)), 64'(m_fl[k]));
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R13 watchdog got timeout exp completion");
      finish_run();
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    #1;
    for (int k = 0; k < 3; k++) cmp("R13 reset flush", k, 0, 64'(got_fl(k)), 64'd0);
    check_all("R13 reset");
    rst_n = 1'b1;
    check_all("R13 after release");

    // R1: every requested previous level
    for (int v = 0; v < 4; v++) begin
      do_write(0, 64'(v) << 11);
      check_all("R1 level sweep");
    end
    // R2: all float/extension state pairs
    for (int fs = 0; fs < 4; fs++)
      for (int xs = 0; xs < 4; xs++) begin
        do_write(0, (64'(fs) << 13) | (64'(xs) << 15));
        check_all("R2 state sweep");
      end
    // R9: toggle translation-related bits
    do_write(0, 64'd1 << 17);
    do_write(0, 64'd1 << 17);
    do_write(1, 64'd1 << 19);
    do_write(1, 64'd0);
    check_all("R9 toggles");

    // R10: alias behaviour with chosen delegation
    do_write(6, 64'h0022);
    do_write(5, ~64'd0);
    do_write(3, ~64'd0);
    check_all("R10 partial deleg");
    do_write(6, 64'h1200);
    do_write(5, 64'd0);
    do_write(3, 64'd0);
    check_all("R10 moved deleg");

    // R8: F clear drags D down
    do_write(10, ~64'd0);
    do_write(10, 64'h8);
    check_all("R8 F-D coupling");
    do_write(10, 64'h28);
    check_all("R8 restore");

    // walking one over every address, mapped or not
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 64; b++) begin
        do_write(a, 64'd1 << b);
        check_all("walk");
      end

    // fill patterns
    for (int a = 0; a < 16; a++) begin
      do_write(a, ~64'd0);             check_all("fill ones");
      do_write(a, 64'h5555_5555_5555_5555); check_all("fill 5");
      do_write(a, 64'hAAAA_AAAA_AAAA_AAAA); check_all("fill A");
      do_write(a, 64'd0);              check_all("fill zero");
    end

    finish_run();
  end
endmodule